// File: doc/BRIEF.md
# Floating-Point Compare Condition Unit

The unit compares two IEEE-754 operands and reports their relation as a two-bit condition code. A precision select chooses between double-precision operands, which use all 64 bits of each input, and single-precision operands, which use only the low 32 bits. A one-cycle compare strobe starts each compare. The condition code, the invalid-operation response and the sticky flag update on the clock edge that samples the strobe.

When either operand is a NaN, the result is unordered. A trap-mask input then picks the response. With the mask set, the unit raises a trap request that lasts exactly one cycle. With the mask clear, it sets a sticky accrued-invalid flag instead. The flag stays set until a status-clear pulse arrives.

A small state machine tracks the outcome of the most recent edge:
- `ST_IDLE`: no compare was sampled on that edge.
- `ST_ORD`: the last compare was ordered.
- `ST_UNORD`: the last compare was unordered and masked off, so the flag was set.
- `ST_TRAP`: the last compare was unordered with the mask set. This is the only state that drives the trap request.

Transitions:
- `go_ordered`: strobe with no NaN, from any state to `ST_ORD`.
- `go_unord_flag`: strobe with a NaN and the mask clear, to `ST_UNORD`.
- `go_unord_trap`: strobe with a NaN and the mask set, to `ST_TRAP`.
- `no_go`: no strobe, from any state back to `ST_IDLE`.

Top module: `fcmp_cond_unit`

## Requirements
- R1: After reset, cc is 2'b00, accrued_inv is 0 and trap_req is 0.
- R2: If either operand is a NaN, cc becomes 2'b11 (unordered). A NaN is any value whose exponent field is all ones and whose fraction is nonzero, whether quiet or signalling. The exponent is bits 62:52 for double and bits 30:23 for single.
- R3: An unordered compare with trap_mask set raises trap_req for exactly one cycle and leaves accrued_inv unchanged.
- R4: An unordered compare with trap_mask clear sets accrued_inv and does not raise trap_req.
- R5: For ordered operands, cc is 2'b01 when A < B, 2'b10 when A > B, and 2'b00 when A == B.
- R6: Positive zero and negative zero compare equal (cc 2'b00).
- R7: With dbl_sel=1 the full 64-bit inputs are compared as doubles. With dbl_sel=0 only bits 31:0 are compared as singles, and bits 63:32 have no effect. Both precisions use the same cc encoding.
- R8: Results appear on the clock edge that samples cmp_go. cc holds its value on cycles without cmp_go.
- R9: accrued_inv stays set across later compares until clr_accrued is sampled high. If an unordered masked-off compare arrives in the same cycle as clr_accrued, the flag ends up set.
- R10: Infinities are ordered, not NaN: +inf is greater than any finite value and -inf is less than any finite value.
- R11: Between two negative operands, the one with the larger magnitude is the lesser.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmp_go | input | 1 | Compare strobe, sampled on the rising edge |
| dbl_sel | input | 1 | 1 = double precision, 0 = single precision (low 32 bits) |
| src_a | input | 64 | Operand A |
| src_b | input | 64 | Operand B |
| trap_mask | input | 1 | Invalid-operation trap enable |
| clr_accrued | input | 1 | Status write that clears the accrued-invalid flag |
| cc | output | 2 | Condition code: 00 equal, 01 less, 10 greater, 11 unordered |
| accrued_inv | output | 1 | Sticky accrued invalid flag |
| trap_req | output | 1 | One-cycle floating-point exception trap request |

## Verification
Every result is due on the first rising edge after the strobe is driven: cc, accrued_inv and trap_req all come from registers loaded on that edge. The bench therefore checks them at the falling edge that follows. The driver pushes one expected item per strobe. The monitor pops it only in a cycle whose preceding edge sampled cmp_go. In every other cycle the monitor confirms that trap_req is low, which shows that the trap lasts exactly one cycle. A flag clear is checked at the falling edge after the edge that sampled clr_accrued.

// File: rtl/fcmp_pkg.sv
package fcmp_pkg;
    parameter int OPW  = 64;
    localparam int MAGW = OPW - 1;

    typedef enum logic [1:0] {
        CC_EQ = 2'b00,
        CC_LT = 2'b01,
        CC_GT = 2'b10,
        CC_UN = 2'b11
    } fcc_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_ORD,
        ST_UNORD,
        ST_TRAP
    } cmp_state_e;

    typedef struct packed {
        logic            sign;
        logic            nan;
        logic            zero;
        logic [MAGW-1:0] mag;
    } opnd_t;
endpackage

// File: rtl/fcmp_unpack.sv
module fcmp_unpack
    import fcmp_pkg::*;
#(
    parameter int DEXP = 11,
    parameter int SEXP = 8
) (
    input  logic [OPW-1:0] raw,
    input  logic           dbl,
    output opnd_t          fields
);
    localparam int SW   = OPW / 2;
    localparam int DMAN = OPW - 1 - DEXP;
    localparam int SMAN = SW - 1 - SEXP;

    logic exp_ones;
    logic man_nz;

    always_comb begin
        if (dbl) begin
            fields.sign = raw[OPW-1];
            exp_ones    = &raw[OPW-2 -: DEXP];
            man_nz      = |raw[DMAN-1:0];
            fields.mag  = raw[OPW-2:0];
        end else begin
            fields.sign = raw[SW-1];
            exp_ones    = &raw[SW-2 -: SEXP];
            man_nz      = |raw[SMAN-1:0];
            fields.mag  = {{(OPW-SW){1'b0}}, raw[SW-2:0]};
        end
        fields.nan  = exp_ones & man_nz;
        fields.zero = (fields.mag == '0);
    end
endmodule

// File: rtl/fcmp_order.sv
module fcmp_order
    import fcmp_pkg::*;
(
    input  opnd_t opa,
    input  opnd_t opb,
    output logic  a_lt,
    output logic  a_gt
);
    logic mag_lt;

    always_comb begin
        a_lt   = 1'b0;
        a_gt   = 1'b0;
        mag_lt = (opa.mag < opb.mag);
        if (opa.zero && opb.zero) begin
            a_lt = 1'b0;
            a_gt = 1'b0;
        end else if (opa.sign != opb.sign) begin
            a_lt = opa.sign;
            a_gt = opb.sign;
        end else if (opa.mag != opb.mag) begin
            a_lt = mag_lt ^ opa.sign;
            a_gt = ~(mag_lt ^ opa.sign);
        end
    end

    // R5: at most one of less / greater
    always_comb begin
        a_r5_exclusive: assert ($onehot0({a_lt, a_gt}));
    end
endmodule

// File: rtl/fcmp_cond_unit.sv
module fcmp_cond_unit
    import fcmp_pkg::*;
#(
    parameter int DEXP = 11,
    parameter int SEXP = 8
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           cmp_go,
    input  logic           dbl_sel,
    input  logic [OPW-1:0] src_a,
    input  logic [OPW-1:0] src_b,
    input  logic           trap_mask,
    input  logic           clr_accrued,
    output logic [1:0]     cc,
    output logic           accrued_inv,
    output logic           trap_req
);
    localparam int NOPS = 2;

    logic [OPW-1:0] raw_op [NOPS];
    opnd_t          op_f   [NOPS];

    assign raw_op[0] = src_a;
    assign raw_op[1] = src_b;

    for (genvar gi = 0; gi < NOPS; gi++) begin : g_unpack
        fcmp_unpack #(.DEXP(DEXP), .SEXP(SEXP)) u_unpack (
            .raw    (raw_op[gi]),
            .dbl    (dbl_sel),
            .fields (op_f[gi])
        );
    end

    logic a_lt, a_gt;

    fcmp_order u_order (
        .opa  (op_f[0]),
        .opb  (op_f[1]),
        .a_lt (a_lt),
        .a_gt (a_gt)
    );

    logic       any_nan;
    fcc_e       cc_next;
    cmp_state_e state_q, state_d;

    always_comb begin
        any_nan = op_f[0].nan | op_f[1].nan;
        if (any_nan)   cc_next = CC_UN;
        else if (a_lt) cc_next = CC_LT;
        else if (a_gt) cc_next = CC_GT;
        else           cc_next = CC_EQ;
    end

    // next-state logic
    always_comb begin
        state_d = ST_IDLE;
        unique case (state_q)
            ST_IDLE, ST_ORD, ST_UNORD, ST_TRAP: begin
                if (!cmp_go)         state_d = ST_IDLE;   // no_go
                else if (!any_nan)   state_d = ST_ORD;    // go_ordered
                else if (trap_mask)  state_d = ST_TRAP;   // go_unord_trap
                else                 state_d = ST_UNORD;  // go_unord_flag
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // output registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cc          <= CC_EQ;
            accrued_inv <= 1'b0;
        end else begin
            if (cmp_go) cc <= cc_next;
            if (state_d == ST_UNORD)  accrued_inv <= 1'b1;
            else if (clr_accrued)     accrued_inv <= 1'b0;
        end
    end

    assign trap_req = (state_q == ST_TRAP);

    // R3: a trap only follows a masked-on strobe, with cc unordered
    a_r3_trap_cause: assert property (@(posedge clk) disable iff (!rst_n)
        trap_req |-> (cc == 2'b11) && $past(cmp_go && trap_mask));

    // R4: flag rises only from an unmasked strobe, never with a trap
    a_r4_flag_no_trap: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(accrued_inv) |-> !trap_req && (cc == 2'b11) && $past(cmp_go && !trap_mask));

    // R8: cc holds without a strobe
    a_r8_cc_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(cmp_go) |-> $stable(cc));

    // R9: flag falls only after a clear
    a_r9_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(accrued_inv) |-> $past(clr_accrued));
endmodule

// File: tb/test_fcmp_cond_unit.sv
module test_fcmp_cond_unit;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmp_go = 1'b0;
    logic        dbl_sel = 1'b1;
    logic [63:0] src_a = '0;
    logic [63:0] src_b = '0;
    logic        trap_mask = 1'b0;
    logic        clr_accrued = 1'b0;
    logic [1:0]  cc;
    logic        accrued_inv;
    logic        trap_req;

    int checks = 0;
    int failures = 0;
    logic exp_acc = 1'b0;
    logic go_seen = 1'b0;
    logic [1:0] q_cc   [$];
    logic       q_trap [$];
    logic       q_acc  [$];
    string      q_tag  [$];

    always #(CLK_PERIOD/2) clk = ~clk;

    fcmp_cond_unit i_fcmp_cond_unit (
        .clk(clk), .rst_n(rst_n), .cmp_go(cmp_go), .dbl_sel(dbl_sel),
        .src_a(src_a), .src_b(src_b), .trap_mask(trap_mask),
        .clr_accrued(clr_accrued), .cc(cc), .accrued_inv(accrued_inv),
        .trap_req(trap_req)
    );

    task automatic check(input string tag, input logic [3:0] act, input logic [3:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic is_nan(input logic [63:0] v, input logic dbl);
        if (dbl) return (v[62:52] == 11'h7FF) && (v[51:0] != 0);
        return (v[30:23] == 8'hFF) && (v[22:0] != 0);
    endfunction

    function automatic real to_real(input logic [63:0] v, input logic dbl);
        real m;
        real r;
        int  e;
        if (dbl) return $bitstoreal(v);
        e = int'(v[30:23]);
        if (e == 255) r = 1.0e300;
        else if (e == 0) r = real'(v[22:0]) * (2.0 ** -149.0);
        else begin
            m = real'({1'b1, v[22:0]});
            r = m * (2.0 ** (real'(e) - 150.0));
        end
        return v[31] ? -r : r;
    endfunction

    function automatic logic [1:0] model_cc(input logic [63:0] a, input logic [63:0] b, input logic dbl);
        real ra, rb;
        if (is_nan(a, dbl) || is_nan(b, dbl)) return 2'b11;
        ra = to_real(a, dbl);
        rb = to_real(b, dbl);
        if (ra < rb) return 2'b01;
        if (ra > rb) return 2'b10;
        return 2'b00;
    endfunction

    task automatic do_cmp(input string tag, input logic [63:0] a, input logic [63:0] b,
                          input logic dbl, input logic mask, input logic clr);
        logic [1:0] e_cc;
        logic       e_trap;
        e_cc   = model_cc(a, b, dbl);
        e_trap = (e_cc == 2'b11) && mask;
        if (e_cc == 2'b11 && !mask) exp_acc = 1'b1;
        else if (clr)               exp_acc = 1'b0;
        q_cc.push_back(e_cc);
        q_trap.push_back(e_trap);
        q_acc.push_back(exp_acc);
        q_tag.push_back(tag);
        src_a = a; src_b = b; dbl_sel = dbl; trap_mask = mask;
        clr_accrued = clr; cmp_go = 1'b1;
        @(negedge clk);
        cmp_go = 1'b0; clr_accrued = 1'b0;
    endtask

    task automatic do_clear();
        clr_accrued = 1'b1;
        exp_acc = 1'b0;
        @(negedge clk);
        clr_accrued = 1'b0;
        check("R9 cleared by status write", {3'b0, accrued_inv}, 4'h0);
    endtask

    always @(posedge clk) go_seen <= rst_n && cmp_go;

    always @(negedge clk) begin
        if (rst_n) begin
            if (go_seen) begin
                if (q_cc.size() == 0) begin
                    check("R8 unexpected result", 4'h1, 4'h0);
                end else begin
                    string t;
                    t = q_tag.pop_front();
                    check({t, " cc"}, {2'b0, cc}, {2'b0, q_cc.pop_front()});
                    check({t, " trap"}, {3'b0, trap_req}, {3'b0, q_trap.pop_front()});
                    check({t, " acc"}, {3'b0, accrued_inv}, {3'b0, q_acc.pop_front()});
                end
            end else begin
                check("R3 trap one cycle only", {3'b0, trap_req}, 4'h0);
            end
        end
    end

    localparam logic [63:0] D_P1   = 64'h3FF0_0000_0000_0000;
    localparam logic [63:0] D_P2   = 64'h4000_0000_0000_0000;
    localparam logic [63:0] D_N1   = 64'hBFF0_0000_0000_0000;
    localparam logic [63:0] D_N2   = 64'hC000_0000_0000_0000;
    localparam logic [63:0] D_PZ   = 64'h0000_0000_0000_0000;
    localparam logic [63:0] D_NZ   = 64'h8000_0000_0000_0000;
    localparam logic [63:0] D_PINF = 64'h7FF0_0000_0000_0000;
    localparam logic [63:0] D_NINF = 64'hFFF0_0000_0000_0000;
    localparam logic [63:0] D_QNAN = 64'h7FF8_0000_0000_0000;
    localparam logic [63:0] D_SNAN = 64'h7FF0_0000_0000_0001;
    localparam logic [63:0] D_MAX  = 64'h7FEF_FFFF_FFFF_FFFF;
    localparam logic [63:0] HI_JUNK = 64'hFFF8_0001_0000_0000;

    initial begin
        #(CLK_PERIOD * 20000);
        failures++;
        checks++;
        $display("FAIL watchdog expired");
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        check("R1 reset cc", {2'b0, cc}, 4'h0);
        check("R1 reset acc", {3'b0, accrued_inv}, 4'h0);
        check("R1 reset trap", {3'b0, trap_req}, 4'h0);
        rst_n = 1'b1;
        @(negedge clk);
        do_cmp("R5 dbl lt",        D_P1, D_P2, 1'b1, 1'b0, 1'b0);
        do_cmp("R5 dbl gt",        D_P2, D_P1, 1'b1, 1'b0, 1'b0);
        do_cmp("R5 dbl eq",        D_P2, D_P2, 1'b1, 1'b0, 1'b0);
        @(negedge clk);
        check("R8 cc holds", {2'b0, cc}, 4'h0);
        do_cmp("R11 neg lt",       D_N2, D_N1, 1'b1, 1'b0, 1'b0);
        do_cmp("R11 neg gt",       D_N1, D_N2, 1'b1, 1'b0, 1'b0);
        do_cmp("R5 mixed sign",    D_N1, D_P1, 1'b1, 1'b0, 1'b0);
        do_cmp("R6 zeros eq",      D_PZ, D_NZ, 1'b1, 1'b0, 1'b0);
        do_cmp("R6 zeros eq rev",  D_NZ, D_PZ, 1'b1, 1'b0, 1'b0);
        do_cmp("R6 negzero vs neg",D_NZ, D_N1, 1'b1, 1'b0, 1'b0);
        do_cmp("R10 pinf gt max",  D_PINF, D_MAX, 1'b1, 1'b0, 1'b0);
        do_cmp("R10 ninf lt",      D_NINF, D_N2, 1'b1, 1'b0, 1'b0);
        do_cmp("R10 inf eq",       D_PINF, D_PINF, 1'b1, 1'b0, 1'b0);
        do_cmp("R3 qnan trap",     D_QNAN, D_P1, 1'b1, 1'b1, 1'b0);
        do_cmp("R3 snan trap b2b", D_P1, D_SNAN, 1'b1, 1'b1, 1'b0);
        @(negedge clk);
        do_cmp("R4 snan flag",     D_SNAN, D_P1, 1'b1, 1'b0, 1'b0);
        do_cmp("R9 flag stays",    D_P1, D_P2, 1'b1, 1'b0, 1'b0);
        do_clear();
        do_cmp("R9 set wins clr",  D_P1, D_QNAN, 1'b1, 1'b0, 1'b1);
        do_cmp("R9 clr with go",   D_P1, D_P1, 1'b1, 1'b0, 1'b1);
        do_cmp("R2 nan eq self",   D_QNAN, D_QNAN, 1'b1, 1'b1, 1'b0);
        do_cmp("R7 sgl lt",        HI_JUNK | 64'h3F80_0000, HI_JUNK | 64'h4000_0000, 1'b0, 1'b0, 1'b0);
        do_cmp("R7 sgl gt neg",    HI_JUNK | 64'hBF80_0000, 64'hC000_0000, 1'b0, 1'b0, 1'b0);
        do_cmp("R7 sgl eq junk",   64'h3F80_0000, 64'h1234_5678_3F80_0000, 1'b0, 1'b0, 1'b0);
        do_cmp("R6 sgl zeros",     64'h8000_0000, 64'h0, 1'b0, 1'b0, 1'b0);
        do_cmp("R7 sgl denorm",    64'h1, 64'h0, 1'b0, 1'b0, 1'b0);
        do_cmp("R10 sgl inf",      64'h7F80_0000, 64'h7F7F_FFFF, 1'b0, 1'b0, 1'b0);
        do_cmp("R2 sgl snan trap", 64'h7F80_0001, 64'h0, 1'b0, 1'b1, 1'b0);
        do_cmp("R2 sgl qnan flag", 64'h0, 64'hFFC0_0000, 1'b0, 1'b0, 1'b0);
        do_clear();
        repeat (3) @(negedge clk);
        check("R8 queue drained", {3'b0, q_cc.size() != 0}, 4'h0);
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule